// File: doc/BRIEF.md
# Command-Phase Port for a Serial Interface Engine

This block sits on a CPU register bus and lets software drive a serial interface engine one byte at a time. Software writes a command word to a code register. Bits 15:8 of that word hold a phase code, and bits 23:16 hold an opcode or a data byte. A command phase selects an operation. It is then followed by a single write-data phase or a single read-data phase. The block applies each operation to a small device model, which holds the bus address, an enable bit, the configured bit and five status bits. The same model also reports a per-endpoint status nibble that comes in from outside the block.

Each phase keeps the engine busy for `LAT` clock cycles. At the end of that time the block raises a handshake flag in an interrupt status word. Command and write phases raise the empty flag. Read phases raise the full flag and load the result into a data register. Software clears either flag by writing ones to a clear register.

The sequencer has five named states:
- IDLE: nothing is pending.
- CMD_RUN: a command phase is being processed.
- ARMED: a command has completed and waits for its data phase.
- WR_RUN: a write-data phase is being processed.
- RD_RUN: a read-data phase is being processed.

Its transitions are:
- IDLE or ARMED goes to CMD_RUN when software writes a known command.
- ARMED goes to WR_RUN when software writes a write phase and the pending command accepts data.
- ARMED goes to RD_RUN when software writes a read phase and the pending command returns data.
- CMD_RUN goes to ARMED when its counter expires.
- WR_RUN and RD_RUN go to IDLE when their counters expire.

The register map uses word addresses:
- 0: status, read.
- 1: clear, write.
- 2: command code, write.
- 3: command data, read.

Top module: `sie_cmd_port`

## Requirements
- R1: A write to word address 2 is decoded with the phase code in bits 15:8 and the opcode or data byte in bits 23:16. The phase codes are 0x05 for command, 0x01 for write data and 0x02 for read data. Any other phase code is ignored.
- R2: A command phase or write phase accepted at clock edge k sets the empty flag after edge k+LAT and not before. The empty flag is bit 4 of the status word at word address 0.
- R3: A read phase accepted at edge k sets the full flag (bit 5 of the status word) after edge k+LAT. At the same time the result appears in bits 7:0 of word address 3, with bits 31:8 read as zero.
- R4: Opcode 0xD0 followed by a write phase loads the device address from data bits 6:0 and the enable bit from data bit 7.
- R5: Opcode 0xFE followed by a write phase stores data bits 4:0 as the device status. The status bits are 0 connect, 1 connect-changed, 2 suspend, 3 suspend-changed and 4 bus reset. Opcode 0xFE followed by a read phase returns those five bits, with bits 7:5 as zero.
- R6: Opcode 0xD8 followed by a write phase sets the configured output to data bit 0.
- R7: An opcode n below NUM_EP selects endpoint n. A following read phase returns that endpoint's nibble from `ep_flags_i[4n+3:4n]` in bits 3:0, with bits 7:4 zero. The nibble's bits are 0 buffer full, 1 stalled, 2 setup received and 3 packet overwritten.
- R8: Writing a one to bit 4 or bit 5 at word address 1 clears that flag and leaves the other flag unchanged. A flag that is set in the same cycle as its clear stays set.
- R9: The following phases are ignored, raise no flag and change no state:
  - a write phase or read phase written in IDLE;
  - a data phase whose direction the pending command does not support;
  - a command phase carrying an unknown opcode.
- R10: Writes to word address 2 while a phase is being processed are ignored.
- R11: After reset the status word, the data register, the address, the enable bit, the configured bit and the device status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| ep_flags_i | input | 4*NUM_EP | Per-endpoint status nibbles |
| dev_addr_o | output | 7 | Device address |
| dev_en_o | output | 1 | Device enable |
| configured_o | output | 1 | Configured state |
| dev_status_o | output | 5 | Device status bits |

## Verification
- **Address opcode:** all 256 data bytes are swept, which distinguishes the address field from the enable bit.
- **Status opcode:** all 32 status values are swept, each written with the unused upper bits set, so both masking and read-back are checked.
- **Endpoint select:** every endpoint is tried with all 16 nibbles while the other endpoints carry the complement, which exposes any indexing error.
- **Protocol corner cases:** separate runs send orphan phases, direction mismatches, unknown phase codes and opcodes, commands written while busy, and clears timed to land on the same edge as a flag set. These show whether each misuse is ignored and whether set has priority over clear.

// File: rtl/sie_cmd_pkg.sv
`timescale 1ns/1ps
package sie_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_RUN,
        ST_ARMED,
        ST_WR_RUN,
        ST_RD_RUN
    } phase_st_t;

    localparam logic [7:0] PH_CMD = 8'h05;
    localparam logic [7:0] PH_WR  = 8'h01;
    localparam logic [7:0] PH_RD  = 8'h02;

    localparam logic [7:0] OP_SET_ADDR = 8'hD0;
    localparam logic [7:0] OP_CONFIG   = 8'hD8;
    localparam logic [7:0] OP_DEV_STAT = 8'hFE;

    localparam logic [1:0] RA_INT_STAT = 2'd0;
    localparam logic [1:0] RA_INT_CLR  = 2'd1;
    localparam logic [1:0] RA_CMD_CODE = 2'd2;
    localparam logic [1:0] RA_CMD_DATA = 2'd3;

    localparam int FLAG_EMPTY_BIT = 4;
    localparam int FLAG_FULL_BIT  = 5;

    function automatic logic op_is_select(input logic [7:0] op, input logic [7:0] ep_limit);
        return op < ep_limit;
    endfunction

    function automatic logic op_takes_write(input logic [7:0] op);
        return (op == OP_SET_ADDR) || (op == OP_CONFIG) || (op == OP_DEV_STAT);
    endfunction

    function automatic logic op_gives_read(input logic [7:0] op, input logic [7:0] ep_limit);
        return (op == OP_DEV_STAT) || op_is_select(op, ep_limit);
    endfunction

    function automatic logic op_known(input logic [7:0] op, input logic [7:0] ep_limit);
        return op_takes_write(op) || op_gives_read(op, ep_limit);
    endfunction

endpackage

// File: rtl/sie_phase_seq.sv
`timescale 1ns/1ps
module sie_phase_seq
    import sie_cmd_pkg::*;
#(
    parameter int LAT    = 4,
    parameter int NUM_EP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       code_wr,
    input  logic [7:0] phase,
    input  logic [7:0] arg,
    output logic       cmd_done,
    output logic       wr_done,
    output logic       rd_done,
    output logic       busy,
    output logic [7:0] op_q,
    output logic [7:0] data_q
);
    localparam int         CW       = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAT_M1 = CW'(LAT - 1);
    localparam logic [7:0] EP_LIMIT = 8'(NUM_EP);

    phase_st_t      state, st_nx;
    logic [CW-1:0]  cnt;
    logic           ready, acc_cmd, acc_wr, acc_rd, expired;

    always_comb begin
        ready   = (state == ST_IDLE) || (state == ST_ARMED);
        acc_cmd = ready && code_wr && (phase == PH_CMD) && op_known(arg, EP_LIMIT);
        acc_wr  = (state == ST_ARMED) && code_wr && (phase == PH_WR) && op_takes_write(op_q);
        acc_rd  = (state == ST_ARMED) && code_wr && (phase == PH_RD) && op_gives_read(op_q, EP_LIMIT);
        expired = (cnt == '0);
    end

    always_comb begin
        st_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (acc_cmd) st_nx = ST_CMD_RUN;
            end
            ST_ARMED: begin
                if (acc_cmd)     st_nx = ST_CMD_RUN;
                else if (acc_wr) st_nx = ST_WR_RUN;
                else if (acc_rd) st_nx = ST_RD_RUN;
            end
            ST_CMD_RUN: begin
                if (expired) st_nx = ST_ARMED;
            end
            ST_WR_RUN: begin
                if (expired) st_nx = ST_IDLE;
            end
            ST_RD_RUN: begin
                if (expired) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            op_q   <= '0;
            data_q <= '0;
        end else if (acc_cmd) begin
            op_q <= arg;
            cnt  <= LAT_M1;
        end else if (acc_wr) begin
            data_q <= arg;
            cnt    <= LAT_M1;
        end else if (acc_rd) begin
            cnt <= LAT_M1;
        end else if (busy && !expired) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        busy     = 1'b0;
        cmd_done = 1'b0;
        wr_done  = 1'b0;
        rd_done  = 1'b0;
        unique case (state)
            ST_IDLE, ST_ARMED: ;
            ST_CMD_RUN: begin busy = 1'b1; cmd_done = expired; end
            ST_WR_RUN:  begin busy = 1'b1; wr_done  = expired; end
            ST_RD_RUN:  begin busy = 1'b1; rd_done  = expired; end
            default: ;
        endcase
    end

    // R9
    orphan_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && code_wr && phase != PH_CMD) |=> (state == ST_IDLE));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expired) |=> ($stable(op_q) && $stable(data_q)));

    // R2
    cmd_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (state == ST_ARMED));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAT_M1));

endmodule

// File: rtl/sie_dev_model.sv
`timescale 1ns/1ps
module sie_dev_model
    import sie_cmd_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic [7:0]        op,
    input  logic [7:0]        data,
    input  logic [4*NUM_EP-1:0] ep_flags,
    output logic [6:0]        dev_addr,
    output logic              dev_en,
    output logic              configured,
    output logic [4:0]        dev_stat,
    output logic [7:0]        rd_byte_q
);
    localparam int         IW       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
    localparam int         SLOTS    = 1 << IW;
    localparam logic [7:0] EP_LIMIT = 8'(NUM_EP);

    logic [3:0] ep_nib [SLOTS];
    logic [7:0] rd_val;

    for (genvar g = 0; g < SLOTS; g++) begin : g_nib
        if (g < NUM_EP) begin : g_live
            assign ep_nib[g] = ep_flags[4*g +: 4];
        end else begin : g_pad
            assign ep_nib[g] = 4'h0;
        end
    end

    always_comb begin
        if (op_is_select(op, EP_LIMIT)) rd_val = {4'h0, ep_nib[op[IW-1:0]]};
        else if (op == OP_DEV_STAT)     rd_val = {3'b000, dev_stat};
        else                            rd_val = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_addr   <= '0;
            dev_en     <= 1'b0;
            configured <= 1'b0;
            dev_stat   <= '0;
        end else if (wr_done) begin
            unique case (op)
                OP_SET_ADDR: begin
                    dev_addr <= data[6:0];
                    dev_en   <= data[7];
                end
                OP_CONFIG:   configured <= data[0];
                OP_DEV_STAT: dev_stat   <= data[4:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_byte_q <= '0;
        else if (rd_done) rd_byte_q <= rd_val;
    end

    // R4
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && op == OP_SET_ADDR) |=> (dev_addr == $past(data[6:0]) && dev_en == $past(data[7])));

    // R5
    stat_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && op == OP_DEV_STAT) |=> (rd_byte_q == {3'b000, $past(dev_stat)}));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && op == OP_CONFIG) |=> $stable(configured));

endmodule

// File: rtl/sie_hs_flags.sv
`timescale 1ns/1ps
module sie_hs_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_empty,
    input  logic set_full,
    input  logic clr_wr,
    input  logic clr_empty_bit,
    input  logic clr_full_bit,
    output logic empty_q,
    output logic full_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            if (set_empty)                        empty_q <= 1'b1;
            else if (clr_wr && clr_empty_bit)     empty_q <= 1'b0;
            if (set_full)                         full_q  <= 1'b1;
            else if (clr_wr && clr_full_bit)      full_q  <= 1'b0;
        end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_empty |=> empty_q);

    // R8
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_empty_bit && !set_empty) |=> !empty_q);

    // R8
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !(clr_wr && clr_full_bit)) |=> full_q);

endmodule

// File: rtl/sie_cmd_port.sv
`timescale 1ns/1ps
module sie_cmd_port
    import sie_cmd_pkg::*;
#(
    parameter int LAT    = 4,
    parameter int NUM_EP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [1:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [4*NUM_EP-1:0] ep_flags_i,
    output logic [6:0]          dev_addr_o,
    output logic                dev_en_o,
    output logic                configured_o,
    output logic [4:0]          dev_status_o
);
    logic       code_wr, clr_wr;
    logic       cmd_done, wr_done, rd_done, busy;
    logic [7:0] op_q, data_q, rd_byte_q;
    logic       empty_q, full_q;

    assign code_wr = bus_wr && (bus_addr == RA_CMD_CODE);
    assign clr_wr  = bus_wr && (bus_addr == RA_INT_CLR);

    sie_phase_seq #(.LAT(LAT), .NUM_EP(NUM_EP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_wr  (code_wr),
        .phase    (bus_wdata[15:8]),
        .arg      (bus_wdata[23:16]),
        .cmd_done (cmd_done),
        .wr_done  (wr_done),
        .rd_done  (rd_done),
        .busy     (busy),
        .op_q     (op_q),
        .data_q   (data_q)
    );

    sie_dev_model #(.NUM_EP(NUM_EP)) u_dev (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_done    (wr_done),
        .rd_done    (rd_done),
        .op         (op_q),
        .data       (data_q),
        .ep_flags   (ep_flags_i),
        .dev_addr   (dev_addr_o),
        .dev_en     (dev_en_o),
        .configured (configured_o),
        .dev_stat   (dev_status_o),
        .rd_byte_q  (rd_byte_q)
    );

    sie_hs_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_empty     (cmd_done | wr_done),
        .set_full      (rd_done),
        .clr_wr        (clr_wr),
        .clr_empty_bit (bus_wdata[FLAG_EMPTY_BIT]),
        .clr_full_bit  (bus_wdata[FLAG_FULL_BIT]),
        .empty_q       (empty_q),
        .full_q        (full_q)
    );

    always_comb begin
        unique case (bus_addr)
            RA_INT_STAT: bus_rdata = {26'd0, full_q, empty_q, 4'd0};
            RA_CMD_DATA: bus_rdata = {24'd0, rd_byte_q};
            default:     bus_rdata = 32'd0;
        endcase
    end

    // R3
    full_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> $past(rd_done));

    // R2
    empty_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_q) |-> $past(cmd_done || wr_done));

    // R10
    busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && code_wr && !(cmd_done || wr_done || rd_done)) |=> $stable(op_q));

endmodule

// File: tb/sim_sie_cmd_port.sv
`timescale 1ns/1ps
module sim_sie_cmd_port;
    localparam int CLK_NS = 10;
    localparam int LAT    = 4;
    localparam int NEP    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [1:0]        bus_addr = 2'd0;
    logic [31:0]       bus_wdata = 32'd0;
    logic [31:0]       bus_rdata;
    logic [4*NEP-1:0]  ep_flags = '0;
    logic [6:0]        dev_addr;
    logic              dev_en, configured;
    logic [4:0]        dev_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    sie_cmd_port #(.LAT(LAT), .NUM_EP(NEP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_flags_i(ep_flags),
        .dev_addr_o(dev_addr), .dev_en_o(dev_en), .configured_o(configured),
        .dev_status_o(dev_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_w(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic send(input logic [7:0] ph, input logic [7:0] b);
        bus_w(2'd2, {8'h00, b, ph, 8'h00});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_stat(input string tag, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(2'd0, v);
        chk(tag, v, exp);
    endtask

    task automatic do_cmd(input logic [7:0] op);
        send(8'h05, op);
        wait_n(LAT);
        expect_stat("R2 cmd empty flag", 32'h10);
        bus_w(2'd1, 32'h30);
    endtask

    task automatic do_wr(input logic [7:0] d);
        send(8'h01, d);
        wait_n(LAT);
        expect_stat("R2 write empty flag", 32'h10);
        bus_w(2'd1, 32'h30);
    endtask

    task automatic do_rd(output logic [31:0] d);
        send(8'h02, 8'h00);
        wait_n(LAT);
        expect_stat("R3 read full flag", 32'h20);
        rd_reg(2'd3, d);
        bus_w(2'd1, 32'h30);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R11 reset state
        expect_stat("R11 status", 32'h0);
        rd_reg(2'd3, v); chk("R11 data reg", v, 32'h0);
        chk("R11 outputs", {dev_addr, dev_en, configured, dev_status}, 0);

        // R1 R2 exact timing of the empty flag
        send(8'h05, 8'hD0);
        wait_n(LAT - 1);
        expect_stat("R2 flag early", 32'h0);
        wait_n(1);
        expect_stat("R2 flag on time", 32'h10);
        bus_w(2'd1, 32'h10);
        expect_stat("R8 clear empty", 32'h0);
        do_wr(8'h2A);
        chk("R1 R4 first address", {dev_en, dev_addr}, 8'h2A);

        // R4 sweep of all data bytes
        for (int d = 0; d < 256; d++) begin
            do_cmd(8'hD0);
            do_wr(8'(d));
            chk("R4 address", {25'd0, dev_addr}, d & 32'h7F);
            chk("R4 enable", {31'd0, dev_en}, (d >> 7) & 1);
        end

        // R5 sweep of all status values, upper bits forced high
        for (int s = 0; s < 32; s++) begin
            do_cmd(8'hFE);
            do_wr(8'(s) | 8'hE0);
            chk("R5 status out", {27'd0, dev_status}, s);
            do_cmd(8'hFE);
            do_rd(v);
            chk("R5 status read", v, s);
        end

        // R6 configure
        foreach (v[i]) if (i < 6) begin
            logic [7:0] pat;
            pat = (i == 0) ? 8'h01 : (i == 1) ? 8'h00 : (i == 2) ? 8'h03 :
                  (i == 3) ? 8'h02 : (i == 4) ? 8'hFF : 8'hFE;
            do_cmd(8'hD8);
            do_wr(pat);
            chk("R6 configured", {31'd0, configured}, pat & 1);
        end

        // R7 endpoint select sweep
        for (int ep = 0; ep < NEP; ep++) begin
            for (int p = 0; p < 16; p++) begin
                for (int k = 0; k < NEP; k++)
                    ep_flags[4*k +: 4] = (k == ep) ? 4'(p) : ~4'(p);
                do_cmd(8'(ep));
                do_rd(v);
                chk("R7 endpoint nibble", v, p);
            end
        end

        // R8 set wins over a same-cycle clear
        send(8'h05, 8'hD8);
        wait_n(LAT - 1);
        bus_w(2'd1, 32'h10);
        expect_stat("R8 set priority", 32'h10);
        bus_w(2'd1, 32'h20);
        expect_stat("R8 clear other bit only", 32'h10);
        bus_w(2'd1, 32'h30);
        do_wr(8'h00);
        chk("R6 unconfigure", {31'd0, configured}, 0);

        // R9 orphan write and read in idle
        send(8'h01, 8'h7F);
        wait_n(LAT + 2);
        expect_stat("R9 orphan write flag", 32'h0);
        chk("R9 orphan write address", {dev_en, dev_addr}, 8'hFF);
        send(8'h02, 8'h00);
        wait_n(LAT + 2);
        expect_stat("R9 orphan read flag", 32'h0);

        // R9 direction mismatch, unknown phase, unknown opcode
        do_cmd(8'hD0);
        send(8'h02, 8'h00);
        wait_n(LAT + 2);
        expect_stat("R9 read after address opcode", 32'h0);
        send(8'h03, 8'h11);
        wait_n(LAT + 2);
        expect_stat("R1 unknown phase code", 32'h0);
        do_wr(8'h13);
        chk("R9 write still armed", {dev_en, dev_addr}, 8'h13);
        do_cmd(8'h00);
        send(8'h01, 8'h55);
        wait_n(LAT + 2);
        expect_stat("R9 write after select", 32'h0);
        send(8'h05, 8'h80);
        wait_n(LAT + 2);
        expect_stat("R9 unknown opcode", 32'h0);
        send(8'h05, 8'(NEP));
        wait_n(LAT + 2);
        expect_stat("R9 select beyond range", 32'h0);

        // R10 command written while busy is dropped
        send(8'h05, 8'hD0);
        send(8'h05, 8'hD8);
        wait_n(LAT - 1);
        expect_stat("R10 single flag", 32'h10);
        bus_w(2'd1, 32'h30);
        do_wr(8'h85);
        chk("R10 address from first opcode", {dev_en, dev_addr}, 8'h85);
        chk("R10 configured untouched", {31'd0, configured}, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule